// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block chooses the address of the next instruction for a processor with 32-bit fixed-width instructions. Every clock it looks at the current program counter, the fetched instruction word, the values of the two source registers named by that instruction, and an enable that permits register-indirect jumps. From these it selects one of four flows: fall through to the following instruction, a conditional branch that compares the two registers and moves by a signed instruction count, an absolute jump that keeps the top bits of the current region, or a jump to an address held in a register.

The result is registered. One clock after an instruction is presented, the unit shows the chosen next PC, a flag saying whether control flow left the sequential path, a link-write strobe with the return address for jump-and-link, and a flag that warns when a register-indirect target is not word aligned. The return address is meant to be written to register 31 by the surrounding pipeline.

Top module: `npc_unit`

## Requirements
- R1: When reset is high at a clock edge, after that edge `npc_o`, `link_data_o` are zero and `taken_o`, `link_we_o`, `misalign_o` are low.
- R2: The opcode is instruction bits [31:26]. For any opcode other than 2, 3, 4 and 5 that is not an enabled register-indirect jump, the next PC is PC + 4 and `taken_o` is low.
- R3: Opcode 4 (branch if equal) with equal register values gives next PC = (PC + 4) + 4 × sign-extended instruction bits [15:0], with `taken_o` high.
- R4: Opcode 4 with different register values gives PC + 4 with `taken_o` low.
- R5: Opcode 5 (branch if not equal) is taken, with the same target rule as R3, when the register values differ, and gives PC + 4 with `taken_o` low when they are equal.
- R6: Opcodes 2 and 3 give next PC = {PC[31:28], instruction bits [25:0], 2'b00}, with `taken_o` high.
- R7: Opcode 3 raises `link_we_o` with `link_data_o` = PC + 4; for every other instruction `link_we_o` is low and `link_data_o` is zero.
- R8: Opcode 0 with function field bits [5:0] = 0x08 while `ind_jump_i` is high loads `rs_val_i` unchanged into the next PC, with `taken_o` high.
- R9: `misalign_o` is high exactly when an R8 jump has a target whose bits [1:0] are not zero; the target is still passed through unchanged.
- R10: Opcode 0 with function 0x08 while `ind_jump_i` is low behaves as sequential flow: PC + 4, `taken_o` low.
- R11: All address sums wrap modulo 2^32 (PC + 4 at 0xFFFFFFFC gives 0; branch targets wrap the same way).
- R12: Outputs change only at the clock edge that follows the inputs; a change of inputs between edges leaves the outputs as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| ind_jump_i | input | 1 | Permits the register-indirect jump encoding to act |
| npc_o | output | 32 | Selected next program counter |
| taken_o | output | 1 | Control flow left the sequential path |
| link_we_o | output | 1 | Return address must be written to register 31 |
| link_data_o | output | 32 | Return address (PC + 4) when `link_we_o` is high |
| misalign_o | output | 1 | Register-indirect target not word aligned |

## Verification
The assertions assume every input is a known value at each clock edge outside reset and that `pc_i` is the address of the presented instruction; they compare the outputs against the inputs captured one edge earlier. The stimulus changes inputs only on the falling edge, always drives defined values, and mixes directed cases with random words whose opcode is steered toward the control-flow encodings, with register pairs forced equal about half the time and register-indirect targets that are both aligned and misaligned.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN     = 32;
    localparam int OPC_W    = 6;
    localparam int FUNCT_W  = 6;
    localparam int IMM_W    = 16;
    localparam int TGT_W    = 26;
    localparam int ALIGN_W  = 2;
    localparam int REGION_W = XLEN - TGT_W - ALIGN_W;
    localparam int SEXT_W   = XLEN - IMM_W - ALIGN_W;

    localparam logic [OPC_W-1:0]   OPC_SPECIAL = 6'd0;
    localparam logic [OPC_W-1:0]   OPC_JUMP    = 6'd2;
    localparam logic [OPC_W-1:0]   OPC_JLINK   = 6'd3;
    localparam logic [OPC_W-1:0]   OPC_BEQ     = 6'd4;
    localparam logic [OPC_W-1:0]   OPC_BNE     = 6'd5;
    localparam logic [FUNCT_W-1:0] FUNCT_JREG  = 6'h08;

    localparam logic [XLEN-1:0] INSTR_BYTES = XLEN'(4);

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BEQ,
        FLOW_BNE,
        FLOW_JABS,
        FLOW_JREG
    } flow_e;

    typedef struct packed {
        flow_e             flow;
        logic              link;
        logic [IMM_W-1:0]  imm;
        logic [TGT_W-1:0]  tgt;
    } dec_t;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] br;
        logic [XLEN-1:0] jabs;
    } targets_t;

    typedef struct packed {
        logic [XLEN-1:0] npc;
        logic            taken;
        logic            link_we;
        logic [XLEN-1:0] link_data;
        logic            misalign;
    } npc_res_t;

    function automatic logic [XLEN-1:0] branch_disp(input logic [IMM_W-1:0] imm);
        return {{SEXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr_i,
    input  logic            ind_jump_i,
    output dec_t            dec_o
);

    logic [OPC_W-1:0]   opc;
    logic [FUNCT_W-1:0] funct;

    assign opc   = instr_i[XLEN-1 -: OPC_W];
    assign funct = instr_i[FUNCT_W-1:0];

    always_comb begin
        dec_o.flow = FLOW_SEQ;
        dec_o.link = 1'b0;
        dec_o.imm  = instr_i[IMM_W-1:0];
        dec_o.tgt  = instr_i[TGT_W-1:0];
        case (opc)
            OPC_JUMP:  dec_o.flow = FLOW_JABS;
            OPC_JLINK: begin
                dec_o.flow = FLOW_JABS;
                dec_o.link = 1'b1;
            end
            OPC_BEQ:   dec_o.flow = FLOW_BEQ;
            OPC_BNE:   dec_o.flow = FLOW_BNE;
            OPC_SPECIAL: begin
                if (funct == FUNCT_JREG && ind_jump_i)
                    dec_o.flow = FLOW_JREG;
            end
            default:   dec_o.flow = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/npc_targets.sv
module npc_targets
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] pc_i,
    input  dec_t            dec_i,
    output targets_t        tgt_o
);

    always_comb begin
        tgt_o.seq  = pc_i + INSTR_BYTES;
        tgt_o.br   = tgt_o.seq + branch_disp(dec_i.imm);
        tgt_o.jabs = {pc_i[XLEN-1 -: REGION_W], dec_i.tgt, {ALIGN_W{1'b0}}};
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  dec_t            dec_i,
    input  targets_t        tgt_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] rt_val_i,
    output npc_res_t        res_o
);

    logic same;
    assign same = (rs_val_i == rt_val_i);

    always_comb begin
        res_o.npc       = tgt_i.seq;
        res_o.taken     = 1'b0;
        res_o.misalign  = 1'b0;
        res_o.link_we   = dec_i.link;
        res_o.link_data = dec_i.link ? tgt_i.seq : '0;
        unique case (dec_i.flow)
            FLOW_BEQ: begin
                res_o.taken = same;
                res_o.npc   = same ? tgt_i.br : tgt_i.seq;
            end
            FLOW_BNE: begin
                res_o.taken = !same;
                res_o.npc   = same ? tgt_i.seq : tgt_i.br;
            end
            FLOW_JABS: begin
                res_o.taken = 1'b1;
                res_o.npc   = tgt_i.jabs;
            end
            FLOW_JREG: begin
                res_o.taken    = 1'b1;
                res_o.npc      = rs_val_i;
                res_o.misalign = |rs_val_i[ALIGN_W-1:0];
            end
            default: begin
                res_o.taken = 1'b0;
                res_o.npc   = tgt_i.seq;
            end
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] instr_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] rt_val_i,
    input  logic            ind_jump_i,
    output logic [XLEN-1:0] npc_o,
    output logic            taken_o,
    output logic            link_we_o,
    output logic [XLEN-1:0] link_data_o,
    output logic            misalign_o
);

    dec_t     dec;
    targets_t tgts;
    npc_res_t res_d;
    npc_res_t res_q;

    npc_decode u_decode (
        .instr_i    (instr_i),
        .ind_jump_i (ind_jump_i),
        .dec_o      (dec)
    );

    npc_targets u_targets (
        .pc_i  (pc_i),
        .dec_i (dec),
        .tgt_o (tgts)
    );

    npc_select u_select (
        .dec_i    (dec),
        .tgt_i    (tgts),
        .rs_val_i (rs_val_i),
        .rt_val_i (rt_val_i),
        .res_o    (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    assign npc_o       = res_q.npc;
    assign taken_o     = res_q.taken;
    assign link_we_o   = res_q.link_we;
    assign link_data_o = res_q.link_data;
    assign misalign_o  = res_q.misalign;

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
    import npc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc_i,
    input logic [XLEN-1:0] instr_i,
    input logic [XLEN-1:0] rs_val_i,
    input logic [XLEN-1:0] rt_val_i,
    input logic            ind_jump_i,
    input logic [XLEN-1:0] npc_o,
    input logic            taken_o,
    input logic            link_we_o,
    input logic [XLEN-1:0] link_data_o,
    input logic            misalign_o
);

    logic            rst_q = 1'b0;
    logic            vld_q = 1'b0;
    logic [XLEN-1:0] pc_q, ins_q, rs_q, rt_q;
    logic            ind_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        vld_q <= !rst;
        pc_q  <= pc_i;
        ins_q <= instr_i;
        rs_q  <= rs_val_i;
        rt_q  <= rt_val_i;
        ind_q <= ind_jump_i;
    end

    logic [OPC_W-1:0] op_q;
    logic             jr_code_q;
    logic [XLEN-1:0]  nxt_q;
    logic [XLEN-1:0]  brt_q;
    assign op_q      = ins_q[31:26];
    assign jr_code_q = (op_q == 6'd0) && (ins_q[5:0] == 6'h08);
    assign nxt_q     = pc_q + 32'd4;
    assign brt_q     = nxt_q + {{14{ins_q[15]}}, ins_q[15:0], 2'b00};

    always @(posedge clk) begin
        if (rst_q) begin
            assert_reset_R1: assert (npc_o == '0 && !taken_o && !link_we_o
                                     && link_data_o == '0 && !misalign_o);
        end
    end

    assert_seq_R2: assert property (@(posedge clk) disable iff (rst)
        (vld_q && !(op_q inside {6'd2, 6'd3, 6'd4, 6'd5}) && !jr_code_q)
        |-> (npc_o == nxt_q && !taken_o));

    assert_beq_taken_R3: assert property (@(posedge clk) disable iff (rst)
        (vld_q && op_q == 6'd4 && rs_q == rt_q) |-> (npc_o == brt_q && taken_o));

    assert_beq_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (vld_q && op_q == 6'd4 && rs_q != rt_q) |-> (npc_o == nxt_q && !taken_o));

    assert_bne_R5: assert property (@(posedge clk) disable iff (rst)
        (vld_q && op_q == 6'd5) |->
        (rs_q != rt_q ? (npc_o == brt_q && taken_o) : (npc_o == nxt_q && !taken_o)));

    assert_jabs_R6: assert property (@(posedge clk) disable iff (rst)
        (vld_q && (op_q == 6'd2 || op_q == 6'd3)) |->
        (npc_o == {pc_q[31:28], ins_q[25:0], 2'b00} && taken_o));

    assert_link_R7: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> (op_q == 6'd3 ? (link_we_o && link_data_o == nxt_q)
                                : (!link_we_o && link_data_o == '0)));

    assert_jreg_R8: assert property (@(posedge clk) disable iff (rst)
        (vld_q && jr_code_q && ind_q) |-> (npc_o == rs_q && taken_o));

    assert_misalign_R9: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> (misalign_o == (jr_code_q && ind_q && rs_q[1:0] != 2'b00)));

    assert_ind_off_R10: assert property (@(posedge clk) disable iff (rst)
        (vld_q && jr_code_q && !ind_q) |-> (npc_o == nxt_q && !taken_o));

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (vld_q && $stable(pc_i) && $stable(instr_i) && $stable(rs_val_i)
         && $stable(rt_val_i) && $stable(ind_jump_i) && !$past(rst)) |=> $stable(npc_o));

endmodule

bind npc_unit npc_unit_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pc_i        (pc_i),
    .instr_i     (instr_i),
    .rs_val_i    (rs_val_i),
    .rt_val_i    (rt_val_i),
    .ind_jump_i  (ind_jump_i),
    .npc_o       (npc_o),
    .taken_o     (taken_o),
    .link_we_o   (link_we_o),
    .link_data_o (link_data_o),
    .misalign_o  (misalign_o)
);

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0, instr_i = '0, rs_val_i = '0, rt_val_i = '0;
    logic        ind_jump_i = 1'b0;
    logic [31:0] npc_o, link_data_o;
    logic        taken_o, link_we_o, misalign_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    npc_unit u_dut (
        .clk(clk), .rst(rst), .pc_i(pc_i), .instr_i(instr_i),
        .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .ind_jump_i(ind_jump_i),
        .npc_o(npc_o), .taken_o(taken_o), .link_we_o(link_we_o),
        .link_data_o(link_data_o), .misalign_o(misalign_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference of the requirements
    function automatic void model(input logic [31:0] pc, ins, rs, rt, input logic ind,
                                  output logic [31:0] e_npc, output logic e_tk,
                                  output logic e_lw, output logic [31:0] e_ld,
                                  output logic e_mis);
        int op  = int'(ins[31:26]);
        int off = int'($signed(ins[15:0]));
        logic [31:0] nxt = pc + 32'd4;
        logic [31:0] brt = nxt + 32'(off * 4);
        e_npc = nxt; e_tk = 1'b0; e_mis = 1'b0;
        e_lw  = (op == 3);
        e_ld  = (op == 3) ? nxt : 32'd0;
        if (op == 4 && rs == rt)               begin e_npc = brt; e_tk = 1'b1; end
        else if (op == 5 && rs != rt)          begin e_npc = brt; e_tk = 1'b1; end
        else if (op == 2 || op == 3)           begin e_npc = {pc[31:28], ins[25:0], 2'b00}; e_tk = 1'b1; end
        else if (op == 0 && ins[5:0] == 6'h08 && ind) begin
            e_npc = rs; e_tk = 1'b1; e_mis = (rs[1:0] != 2'b00);
        end
    endfunction

    function automatic string tag_of(input logic [31:0] ins, rs, rt, input logic ind);
        int op = int'(ins[31:26]);
        if (op == 4) return (rs == rt) ? "R3" : "R4";
        if (op == 5) return "R5";
        if (op == 3) return "R7";
        if (op == 2) return "R6";
        if (op == 0 && ins[5:0] == 6'h08) return ind ? ((rs[1:0] != 0) ? "R9" : "R8") : "R10";
        return "R2";
    endfunction

    task automatic compare(input string tag, input logic [31:0] e_npc, input logic e_tk,
                           input logic e_lw, input logic [31:0] e_ld, input logic e_mis);
        n_checks++;
        if (npc_o !== e_npc || taken_o !== e_tk || link_we_o !== e_lw
            || link_data_o !== e_ld || misalign_o !== e_mis) begin
            n_fail++;
            $display("FAIL %s: npc=%h tk=%b lw=%b ld=%h mis=%b expected npc=%h tk=%b lw=%b ld=%h mis=%b",
                     tag, npc_o, taken_o, link_we_o, link_data_o, misalign_o,
                     e_npc, e_tk, e_lw, e_ld, e_mis);
        end
    endtask

    // Drive at the falling edge, sample just after the next rising edge
    task automatic step(input logic [31:0] pc, ins, rs, rt, input logic ind, input string tag);
        logic [31:0] e_npc, e_ld;
        logic e_tk, e_lw, e_mis;
        @(negedge clk);
        pc_i = pc; instr_i = ins; rs_val_i = rs; rt_val_i = rt; ind_jump_i = ind;
        model(pc, ins, rs, rt, ind, e_npc, e_tk, e_lw, e_ld, e_mis);
        @(posedge clk); #1;
        compare(tag, e_npc, e_tk, e_lw, e_ld, e_mis);
    endtask

    function automatic logic [31:0] mk_i(input int op, input logic [25:0] rest);
        return {6'(op), rest};
    endfunction

    initial begin
        logic [31:0] e_npc, e_ld;
        logic e_tk, e_lw, e_mis;
        // R1: reset with busy inputs
        @(negedge clk);
        pc_i = 32'h1234_5670; instr_i = mk_i(3, 26'h3ff_ffff); rs_val_i = 32'h7; ind_jump_i = 1'b1;
        @(posedge clk); #1;
        compare("R1", 32'd0, 1'b0, 1'b0, 32'd0, 1'b0);
        @(negedge clk); rst = 1'b0;

        // Directed cases
        step(32'h0040_0000, 32'h0000_1025, 32'd0, 32'd0, 1'b0, "R2");
        step(32'h0040_0008, 32'h1100_0003, 32'd5, 32'd5, 1'b0, "R3");   // 0x00400018
        step(32'h0040_0010, mk_i(4, 26'h000_FFFF), 32'd9, 32'd9, 1'b0, "R3"); // offset -1
        step(32'h0040_0008, 32'h1100_0003, 32'd5, 32'd6, 1'b0, "R4");
        step(32'h0040_0100, mk_i(5, 26'h000_8000), 32'd1, 32'd2, 1'b0, "R5"); // most negative
        step(32'h0040_0100, mk_i(5, 26'h000_7FFF), 32'd3, 32'd3, 1'b0, "R5");
        step(32'h0040_0014, 32'h0810_0001, 32'd0, 32'd0, 1'b0, "R6");   // 0x00400004
        step(32'hA000_0040, mk_i(3, 26'h000_0010), 32'd0, 32'd0, 1'b0, "R7");
        step(32'h0040_0020, 32'h03E0_0008, 32'h8000_1000, 32'd0, 1'b1, "R8");
        step(32'h0040_0020, 32'h03E0_0008, 32'h8000_1003, 32'd0, 1'b1, "R9");
        step(32'h0040_0020, 32'h03E0_0008, 32'h8000_1002, 32'd0, 1'b0, "R10");
        step(32'hFFFF_FFFC, 32'h0000_0000, 32'd0, 32'd0, 1'b0, "R11");
        step(32'hFFFF_FFF8, mk_i(4, 26'h000_0004), 32'd1, 32'd1, 1'b0, "R11");

        // R12: outputs hold when inputs change between edges
        model(pc_i, instr_i, rs_val_i, rt_val_i, ind_jump_i, e_npc, e_tk, e_lw, e_ld, e_mis);
        @(negedge clk);
        pc_i = 32'h0000_4000; instr_i = mk_i(2, 26'h155_5555); ind_jump_i = 1'b1;
        #1;
        compare("R12", e_npc, e_tk, e_lw, e_ld, e_mis);

        // Random mix, compared every clock
        for (int k = 0; k < 400; k++) begin
            logic [31:0] pc, ins, rs, rt;
            logic ind;
            int sel = int'($urandom_range(0, 6));
            pc  = {$urandom()} & 32'hFFFF_FFFC;
            ins = $urandom();
            case (sel)
                0: ins[31:26] = 6'd2;
                1: ins[31:26] = 6'd3;
                2: ins[31:26] = 6'd4;
                3: ins[31:26] = 6'd5;
                4: begin ins[31:26] = 6'd0; ins[5:0] = 6'h08; end
                default: ;
            endcase
            rs  = $urandom();
            rt  = ($urandom_range(0, 1) == 1) ? rs : $urandom();
            ind = ($urandom_range(0, 3) != 0);
            step(pc, ins, rs, rt, ind, tag_of(ins, rs, rt, ind));
        end

        // R1 again: reset mid-run
        @(negedge clk); rst = 1'b1; instr_i = mk_i(2, 26'h1);
        @(posedge clk); #1;
        compare("R1", 32'd0, 1'b0, 1'b0, 32'd0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule